// File: doc/BRIEF.md
# Two-Wire Serial Programming Port

This block is the device-side end of a two-wire programming link. A host holds the serial clock and data pins low while the programming-voltage indication rises. The block then enters program/verify mode and clears its address counter. After that, every transaction starts with a six-bit command clocked in on the serial clock line. Some commands are followed by a sixteen-clock payload frame that carries one fourteen-bit word. The command decides whether the host drives that word into the device or the device drives it back out on the same data line.

Addresses below the size of the program array go to a simple synchronous-write, combinational-read port on an external array model. Four identification words sit just above the configuration base address at 2000h. They are held inside the block, and only their low seven bits are kept. The port is the only way to reach them, and the port does nothing while program/verify mode is off. Any other address reads as zero and discards writes.

Top module: `pgm_serial_port`

## Requirements
- R1: While reset is high, and in the first cycle after it, prog_mode, sdat_oe and mem_we are all 0.
- R2: A rising edge of vpp_high with sclk and sdat_in both 0 in that cycle sets prog_mode one cycle later. A rise with either pin high leaves prog_mode at 0. vpp_high at 0 clears prog_mode on the next cycle.
- R3: Entering program/verify mode sets the address counter to 0, so the first read returns the word at address 0.
- R4: sdat_in is sampled on each falling edge of sclk. A command is six bits sent least significant bit first. The codes are: 000000 load configuration, 000010 load data, 000100 read data, 000110 increment address.
- R5: After a load data command, the next 16 falling edges carry a frame: bit 0 is the start bit, bits 1 to 14 are the word least significant bit first, and bit 15 is the stop bit. If the address is inside the program array, the word is written there with a single-cycle mem_we pulse.
- R6: After a read data command, the device drives the data line for exactly 16 clocks. It sends a 0 start bit, then the 14-bit word least significant bit first, then a 0 stop bit. sdat_oe is 0 again once the 16th falling edge has been taken.
- R7: The increment address command adds one to the address counter and takes no payload.
- R8: The load configuration command sets the address counter to 2000h and then takes a load payload that is written at that address.
- R9: Addresses 2000h to 2003h hold four identification words. Only bits 6:0 are stored, bits 13:7 read as zero, and writes to these addresses never assert mem_we.
- R10: A command code not listed in R4 is ignored: the address does not change, nothing is driven, and the next six falling edges form a new command.
- R11: Outside program/verify mode, activity on sclk and sdat_in never asserts sdat_oe or mem_we.
- R12: Addresses that are neither in the program array nor identification words read as zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| vpp_high | input | 1 | Programming-voltage level detected on the reset pin |
| sclk | input | 1 | Serial programming clock from the host |
| sdat_in | input | 1 | Resolved level of the serial data line |
| sdat_out | output | 1 | Value the device drives on the data line |
| sdat_oe | output | 1 | Output enable for the data line driver |
| prog_mode | output | 1 | Program/verify mode is active |
| mem_addr | output | 11 | Program array word address |
| mem_wdata | output | 14 | Word to write into the program array |
| mem_we | output | 1 | Single-cycle write strobe to the program array |
| mem_rdata | input | 14 | Combinational read data from the program array |

## Verification
The pins pass through two register stages, so a falling sclk edge is acted on in the second clock after the pin drops. The bench holds every sclk phase for four system clocks. It samples the data line and sdat_oe late in the high phase, by which time the previous edge has moved the output to the next frame bit. Array writes and identification updates appear within three clocks of the last payload edge, and they are always checked later by a read frame, never at an edge. Mode entry and exit are checked two clocks after vpp_high changes, which is one cycle past the register that follows the input.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    localparam int PGM_DATA_W = 14;
    localparam int PGM_CMD_W  = 6;
    localparam int PGM_ADDR_W = 14;

    localparam logic [PGM_CMD_W-1:0] OP_LOAD_CFG  = 6'b000000;
    localparam logic [PGM_CMD_W-1:0] OP_LOAD_DATA = 6'b000010;
    localparam logic [PGM_CMD_W-1:0] OP_READ_DATA = 6'b000100;
    localparam logic [PGM_CMD_W-1:0] OP_INC_ADDR  = 6'b000110;

    typedef enum logic [1:0] {
        PS_CMD  = 2'd0,
        PS_LOAD = 2'd1,
        PS_READ = 2'd2
    } pgm_state_e;

    typedef struct packed {
        logic cfg;
        logic load;
        logic read;
        logic inc;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [PGM_CMD_W-1:0] code);
        op_dec_t d;
        d.cfg  = (code == OP_LOAD_CFG);
        d.load = (code == OP_LOAD_DATA) || (code == OP_LOAD_CFG);
        d.read = (code == OP_READ_DATA);
        d.inc  = (code == OP_INC_ADDR);
        return d;
    endfunction

endpackage

// File: rtl/pgm_pin_sync.sv
module pgm_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic vpp_high,
    input  logic sclk,
    input  logic sdat_in,
    output logic sclk_fall,
    output logic sdat_s,
    output logic vpp_rise,
    output logic pins_low
);
    logic sclk_q1;
    logic sclk_q2;
    logic sdat_q1;
    logic vpp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q1 <= 1'b0;
            sclk_q2 <= 1'b0;
            sdat_q1 <= 1'b0;
            vpp_q   <= vpp_high;
        end else begin
            sclk_q1 <= sclk;
            sclk_q2 <= sclk_q1;
            sdat_q1 <= sdat_in;
            vpp_q   <= vpp_high;
        end
    end

    assign sclk_fall = sclk_q2 & ~sclk_q1;
    assign sdat_s    = sdat_q1;
    assign vpp_rise  = vpp_high & ~vpp_q;
    assign pins_low  = ~sclk & ~sdat_in;

endmodule

// File: rtl/pgm_id_store.sv
module pgm_id_store #(
    parameter int ID_COUNT = 4,
    parameter int ID_W     = 7,
    parameter int DATA_W   = 14,
    localparam int IDX_W   = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word
);
    logic [ID_W-1:0] words [ID_COUNT];

    for (genvar g = 0; g < ID_COUNT; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (wr_en && (int'(idx) == g)) begin
                words[g] <= wr_word[ID_W-1:0];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < ID_COUNT; i++) begin
            if (int'(idx) == i) begin
                rd_word[ID_W-1:0] = words[i];
            end
        end
    end

endmodule

// File: rtl/pgm_serial_port.sv
module pgm_serial_port
    import pgm_pkg::*;
#(
    parameter int DATA_W   = PGM_DATA_W,
    parameter int CMD_W    = PGM_CMD_W,
    parameter int ADDR_W   = PGM_ADDR_W,
    parameter int MEM_AW   = 11,
    parameter int ID_COUNT = 4,
    parameter int ID_W     = 7,
    parameter logic [ADDR_W-1:0] ID_BASE = 14'h2000,
    localparam int FRAME_W = DATA_W + 2,
    localparam int CNT_W   = $clog2(FRAME_W) + 1,
    localparam int IDX_W   = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vpp_high,
    input  logic              sclk,
    input  logic              sdat_in,
    output logic              sdat_out,
    output logic              sdat_oe,
    output logic              prog_mode,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);

    logic sclk_fall;
    logic sdat_s;
    logic vpp_rise;
    logic pins_low;

    pgm_pin_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .vpp_high (vpp_high),
        .sclk     (sclk),
        .sdat_in  (sdat_in),
        .sclk_fall(sclk_fall),
        .sdat_s   (sdat_s),
        .vpp_rise (vpp_rise),
        .pins_low (pins_low)
    );

    pgm_state_e         state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [ADDR_W-1:0]  addr;

    logic               in_mem;
    logic               in_id;
    logic [ADDR_W-1:0]  id_off;
    logic [DATA_W-1:0]  id_rd;
    logic [DATA_W-1:0]  cur_word;
    logic [CMD_W-1:0]   cmd_full;
    op_dec_t            op;
    logic [DATA_W-1:0]  load_word;
    logic               load_done;
    logic               id_wr;

    assign in_mem    = (addr < ADDR_W'(2 ** MEM_AW));
    assign id_off    = addr - ID_BASE;
    assign in_id     = (addr >= ID_BASE) && (id_off < ADDR_W'(ID_COUNT));
    assign cmd_full  = {sdat_s, shreg[FRAME_W-1 -: CMD_W-1]};
    assign op        = decode_op(cmd_full);
    assign load_word = shreg[FRAME_W-1:2];
    assign load_done = prog_mode && vpp_high && sclk_fall
                       && (state == PS_LOAD) && (bit_cnt == FRAME_LAST);
    assign id_wr     = load_done && in_id;
    assign mem_addr  = addr[MEM_AW-1:0];

    pgm_id_store #(
        .ID_COUNT(ID_COUNT),
        .ID_W    (ID_W),
        .DATA_W  (DATA_W)
    ) u_ids (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (id_wr),
        .idx    (id_off[IDX_W-1:0]),
        .wr_word(load_word),
        .rd_word(id_rd)
    );

    always_comb begin
        if (in_mem)     cur_word = mem_rdata;
        else if (in_id) cur_word = id_rd;
        else            cur_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_mode <= 1'b0;
            state     <= PS_CMD;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr      <= '0;
            sdat_oe   <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (!vpp_high) begin
                prog_mode <= 1'b0;
                state     <= PS_CMD;
                bit_cnt   <= '0;
                sdat_oe   <= 1'b0;
            end else if (vpp_rise && pins_low) begin
                prog_mode <= 1'b1;
                state     <= PS_CMD;
                bit_cnt   <= '0;
                shreg     <= '0;
                addr      <= '0;
                sdat_oe   <= 1'b0;
            end else if (prog_mode && sclk_fall) begin
                unique case (state)
                    PS_CMD: begin
                        shreg <= {sdat_s, shreg[FRAME_W-1:1]};
                        if (bit_cnt == CMD_LAST) begin
                            bit_cnt <= '0;
                            if (op.load) begin
                                state <= PS_LOAD;
                                if (op.cfg) addr <= ID_BASE;
                            end else if (op.read) begin
                                state   <= PS_READ;
                                shreg   <= {1'b0, cur_word, 1'b0};
                                sdat_oe <= 1'b1;
                            end else if (op.inc) begin
                                addr <= addr + 1'b1;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PS_LOAD: begin
                        shreg <= {sdat_s, shreg[FRAME_W-1:1]};
                        if (bit_cnt == FRAME_LAST) begin
                            bit_cnt <= '0;
                            state   <= PS_CMD;
                            if (in_mem) begin
                                mem_we    <= 1'b1;
                                mem_wdata <= load_word;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PS_READ: begin
                        shreg <= {1'b0, shreg[FRAME_W-1:1]};
                        if (bit_cnt == FRAME_LAST) begin
                            bit_cnt <= '0;
                            state   <= PS_CMD;
                            sdat_oe <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: state <= PS_CMD;
                endcase
            end
        end
    end

    assign sdat_out = sdat_oe & shreg[0];

endmodule

// File: rtl/pgm_serial_port_chk.sv
module pgm_serial_port_chk #(
    parameter int FRAME_W = 16
) (
    input logic clk,
    input logic rst,
    input logic vpp_high,
    input logic sclk,
    input logic sdat_in,
    input logic prog_mode,
    input logic sdat_oe,
    input logic mem_we
);
    logic c1;
    logic c2;
    logic [7:0] oe_falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            c1       <= 1'b0;
            c2       <= 1'b0;
            oe_falls <= '0;
        end else begin
            c1 <= sclk;
            c2 <= c1;
            if (!sdat_oe)           oe_falls <= '0;
            else if (c2 && !c1)     oe_falls <= oe_falls + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!prog_mode && !sdat_oe && !mem_we)); // R1
    AST_MODE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ($rose(vpp_high) && !sclk && !sdat_in) |=> prog_mode); // R2
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst) !vpp_high |=> !prog_mode); // R2
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R5
    AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst) oe_falls <= 8'(FRAME_W)); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !prog_mode |-> (!sdat_oe && !mem_we)); // R11

endmodule

bind pgm_serial_port pgm_serial_port_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .vpp_high (vpp_high),
    .sclk     (sclk),
    .sdat_in  (sdat_in),
    .prog_mode(prog_mode),
    .sdat_oe  (sdat_oe),
    .mem_we   (mem_we)
);

// File: tb/pgm_serial_port_bench.sv
module pgm_serial_port_bench;
    localparam int MEM_AW = 11;
    localparam int MEM_N  = 2 ** MEM_AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vpp_high = 1'b0;
    logic sclk = 1'b0;
    logic host_drv = 1'b0;
    logic sdat_in;
    logic sdat_out;
    logic sdat_oe;
    logic prog_mode;
    logic [MEM_AW-1:0] mem_addr;
    logic [13:0] mem_wdata;
    logic mem_we;
    logic [13:0] mem_rdata;

    logic [13:0] array_q [MEM_N];
    logic [13:0] shadow  [MEM_N];
    logic [6:0]  id_model [4];
    logic [13:0] model_addr;
    int checks = 0;
    int errors = 0;
    int we_count = 0;

    always #10 clk = ~clk;

    assign sdat_in   = sdat_oe ? sdat_out : host_drv;
    assign mem_rdata = array_q[mem_addr];

    always_ff @(posedge clk) begin
        if (mem_we) begin
            array_q[mem_addr] <= mem_wdata;
            we_count <= we_count + 1;
        end
    end

    pgm_serial_port u_pgm_serial_port (
        .clk(clk), .rst(rst), .vpp_high(vpp_high), .sclk(sclk),
        .sdat_in(sdat_in), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
        .prog_mode(prog_mode), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    function automatic logic [13:0] init_word(input int a);
        return 14'((a * 37) ^ 14'h2A5A);
    endfunction

    function automatic logic [13:0] exp_read(input logic [13:0] a);
        if (int'(a) < MEM_N) return shadow[a[MEM_AW-1:0]];
        if (a >= 14'h2000 && a <= 14'h2003) return {7'b0, id_model[a[1:0]]};
        return 14'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clk_bit(input logic b);
        host_drv = b;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) clk_bit(c[i]);
        host_drv = 1'b0;
    endtask

    task automatic send_frame(input logic [13:0] w);
        clk_bit(1'b0);
        for (int i = 0; i < 14; i++) clk_bit(w[i]);
        clk_bit(1'b0);
        host_drv = 1'b0;
    endtask

    task automatic recv_frame(output logic [13:0] w, output logic [15:0] raw, output int oe_bits);
        oe_bits = 0;
        for (int i = 0; i < 16; i++) begin
            host_drv = 1'b0;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            raw[i] = sdat_in;
            if (sdat_oe) oe_bits++;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        w = raw[14:1];
    endtask

    task automatic do_load(input logic [13:0] w);
        send_cmd(6'b000010);
        send_frame(w);
        if (int'(model_addr) < MEM_N) shadow[model_addr[MEM_AW-1:0]] = w;
        else if (model_addr >= 14'h2000 && model_addr <= 14'h2003) id_model[model_addr[1:0]] = w[6:0];
    endtask

    task automatic do_read_check(input string req);
        logic [13:0] w;
        logic [15:0] raw;
        int oe_bits;
        send_cmd(6'b000100);
        recv_frame(w, raw, oe_bits);
        check(req, {18'b0, w}, {18'b0, exp_read(model_addr)});
        check("R6 framing", {30'b0, raw[15], raw[0]}, 32'h0);
        check("R6 drive window", oe_bits, 16);
        check("R6 release", {31'b0, sdat_oe}, 32'h0);
    endtask

    task automatic enter_mode();
        vpp_high = 1'b0;
        sclk = 1'b0;
        host_drv = 1'b0;
        repeat (3) @(negedge clk);
        vpp_high = 1'b1;
        repeat (2) @(negedge clk);
        model_addr = 14'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] w;
        logic [15:0] raw;
        int oe_bits;
        int we_before;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < MEM_N; i++) begin
            array_q[i] = init_word(i);
            shadow[i]  = init_word(i);
        end
        for (int i = 0; i < 4; i++) id_model[i] = 7'h0;
        model_addr = 14'h0;

        repeat (3) @(negedge clk);
        check("R1 prog_mode in reset", {31'b0, prog_mode}, 0);
        check("R1 oe in reset", {31'b0, sdat_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 quiet after reset", {30'b0, prog_mode, mem_we}, 0);

        // R11: clocking in normal mode
        we_before = we_count;
        send_cmd(6'b000010);
        send_frame(14'h1555);
        send_cmd(6'b000100);
        recv_frame(w, raw, oe_bits);
        check("R11 no drive outside mode", oe_bits, 0);
        check("R11 no write outside mode", we_count - we_before, 0);

        // R2: entry blocked with clock high
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        vpp_high = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 no entry with sclk high", {31'b0, prog_mode}, 0);
        sclk = 1'b0;
        vpp_high = 1'b0;
        repeat (2) @(negedge clk);
        host_drv = 1'b1;
        vpp_high = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 no entry with sdat high", {31'b0, prog_mode}, 0);
        host_drv = 1'b0;

        enter_mode();
        check("R2 entry", {31'b0, prog_mode}, 1);
        do_read_check("R3 address zero after entry");

        // R5 / R7: write then read a few words
        do_load(14'h3ABC);
        do_read_check("R5 load data");
        send_cmd(6'b000110);
        model_addr = model_addr + 1;
        do_read_check("R7 increment");

        // R10: unknown command, then normal read at same address
        send_cmd(6'b111111);
        check("R10 no drive after unknown", {31'b0, sdat_oe}, 0);
        do_read_check("R10 address kept");

        // R8 / R9: configuration space
        send_cmd(6'b000000);
        model_addr = 14'h2000;
        we_before = we_count;
        send_frame(14'h3FFF);
        id_model[0] = 7'h7F;
        check("R9 id write no mem_we", we_count - we_before, 0);
        do_read_check("R8 R9 id masked");
        for (int i = 1; i < 4; i++) begin
            send_cmd(6'b000110);
            model_addr = model_addr + 1;
            do_load(14'(14'h2A80 | 14'(i * 9)));
            do_read_check("R9 id word");
        end
        send_cmd(6'b000110);
        model_addr = model_addr + 1;
        we_before = we_count;
        do_load(14'h1234);
        check("R12 write discarded", we_count - we_before, 0);
        do_read_check("R12 reads zero");

        // R2 exit
        vpp_high = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 exit", {31'b0, prog_mode}, 0);

        // Random mix
        enter_mode();
        do_read_check("R3 re-entry");
        for (int n = 0; n < 60; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                do_load(14'($urandom));
            end else if (op < 6) begin
                do_read_check("R5 R6 random read");
            end else if (op < 8) begin
                send_cmd(6'b000110);
                model_addr = model_addr + 1;
            end else if (op == 8) begin
                logic [5:0] c;
                c = 6'($urandom);
                if (c == 6'b000000 || c == 6'b000010 || c == 6'b000100 || c == 6'b000110)
                    c = 6'b101010;
                send_cmd(c);
            end else begin
                vpp_high = 1'b0;
                repeat (2) @(negedge clk);
                enter_mode();
            end
        end
        do_read_check("R4 final read");
        for (int i = 0; i < 4; i++) begin
            enter_mode();
            send_cmd(6'b000000);
            model_addr = 14'h2000;
            send_frame({7'h55, 7'(i)});
            id_model[0] = 7'(i);
            do_read_check("R8 id0 rewrite");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule